// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Wrap Pulse and Upper-Word Counter

This block multiplies two operands each clock and adds the product into a registered accumulator of fixed width. A mode input chooses unsigned or two's complement signed arithmetic for both the multiply and the accumulation. An operand narrower than the native multiplier width is widened first. In unsigned mode the new upper bits are zeros. In signed mode they are copies of the operand's top bit. The native width is 9, 18 or 36 bits, whichever is the smallest that holds the operand.

Each time an add makes the accumulator wrap, a single-cycle pulse is raised. What counts as a wrap depends on the mode. In unsigned mode it is a carry out of the top bit. In signed mode it is two addends of the same sign giving a sum of the other sign. A small upper-word counter follows these pulses. Unsigned wraps always count up. A signed wrap counts up when the addend was positive and down when it was negative.

The counter and the accumulator together give a wider running total, equal to `ext_hi * 2^ACC_W + acc_out`. In this formula `acc_out` is read as signed in signed mode, and `ext_hi` is read as signed in signed mode. A load input restarts the sum from the present product.

Top module: `mac_ovf_unit`

## Requirements
- R1: A synchronous reset sets `acc_out`, `wrap_pulse` and `ext_hi` to zero. Reset takes priority over every other input.
- R2: In unsigned mode the bits of an operand above OP_W are filled with zeros. In signed mode they are copies of bit OP_W-1. With OP_W=5, the operand pattern 11010 times 1, loaded with ACC_W=12, gives 26 in unsigned mode and 4090 (that is, -6) in signed mode.
- R3: With `acc_en`=1 and `load`=0, the next `acc_out` is the current `acc_out` plus `op_a*op_b`, taken modulo 2^ACC_W. It appears one clock after the inputs are applied.
- R4: With `acc_en`=0 and `load`=0, `acc_out` and `ext_hi` keep their values and `wrap_pulse` is 0 on the next cycle.
- R5: `load`=1 clears `ext_hi` and `wrap_pulse` on the next cycle. It also sets `acc_out` to the product if `acc_en`=1, or to zero if `acc_en`=0.
- R6: In unsigned mode (`is_signed`=0), `wrap_pulse` is 1 after an add exactly when the sum is smaller than the previous `acc_out`, which means a carry out of bit ACC_W-1.
- R7: In signed mode (`is_signed`=1), `wrap_pulse` is 1 after an add exactly when the previous `acc_out` and the addend have equal top bits and the sum's top bit differs from them.
- R8: `wrap_pulse` is never sticky. It is high only in the cycle right after an accumulating add that wrapped.
- R9: On each wrap, `ext_hi` changes by +1 in unsigned mode. In signed mode it changes by +1 when the addend is positive and by -1 when the addend is negative, modulo 2^EXT_W. Without a wrap or a load, `ext_hi` does not change.
- R10: As long as `ext_hi` does not itself wrap, `ext_hi*2^ACC_W + acc_out` equals the exact sum of all products since the last load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Restart the sum from the present product (or from zero) |
| acc_en | input | 1 | Accumulate enable; also marks the product as valid for a load |
| is_signed | input | 1 | 1: two's complement arithmetic, 0: unsigned |
| op_a | input | OP_W | Multiplicand |
| op_b | input | OP_W | Multiplier |
| acc_out | output | ACC_W | Registered accumulator |
| wrap_pulse | output | 1 | Single-cycle wrap indication |
| ext_hi | output | EXT_W | Upper-word counter of wrap events |

## Verification
The bench builds the block with OP_W=5, which gives a native width of 9, together with ACC_W=12 and EXT_W=4. With the 12-bit accumulator, four to eight maximal products are enough to cross the unsigned carry boundary or the signed 2047/-2048 boundary. This keeps both wrap rules, the down-count of a negative signed wrap and the 4-bit counter underflow reachable in a few cycles. The 5-bit operands are widened by four bits, so the zero-fill and sign-copy paths give clearly different products for the same bit pattern.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Direction in which the upper-word counter moves after an add
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Smallest native multiplier width that holds an operand of w bits
    function automatic int native_width(input int w);
        if (w <= 9) begin
            return 9;
        end else if (w <= 18) begin
            return 18;
        end
        return 36;
    endfunction

endpackage

// File: rtl/mac_opnd_widen.sv
module mac_opnd_widen #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 9
) (
    input  logic             is_signed,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W == 0) begin : g_same
            assign dout = din;
        end else begin : g_pad
            logic fill_bit;
            assign fill_bit = is_signed & din[IN_W-1];
            assign dout     = {{PAD_W{fill_bit}}, din};
        end
    endgenerate
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = 5,
    parameter int NAT_W = 9,
    parameter int ACC_W = 20
) (
    input  logic             is_signed,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] addend
);
    logic [NAT_W-1:0] nat_a;
    logic [NAT_W-1:0] nat_b;
    logic [ACC_W-1:0] wide_a;
    logic [ACC_W-1:0] wide_b;

    // Operands to the native multiplier width
    mac_opnd_widen #(.IN_W(OP_W), .OUT_W(NAT_W)) u_nat_a (
        .is_signed(is_signed), .din(op_a), .dout(nat_a)
    );
    mac_opnd_widen #(.IN_W(OP_W), .OUT_W(NAT_W)) u_nat_b (
        .is_signed(is_signed), .din(op_b), .dout(nat_b)
    );

    // Native operands to accumulator width; the low ACC_W product bits
    // of the widened operands are the product modulo 2^ACC_W in both modes
    mac_opnd_widen #(.IN_W(NAT_W), .OUT_W(ACC_W)) u_acc_a (
        .is_signed(is_signed), .din(nat_a), .dout(wide_a)
    );
    mac_opnd_widen #(.IN_W(NAT_W), .OUT_W(ACC_W)) u_acc_b (
        .is_signed(is_signed), .din(nat_b), .dout(wide_b)
    );

    assign addend = wide_a * wide_b;
endmodule

// File: rtl/mac_wrap_detect.sv
module mac_wrap_detect
    import mac_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic             is_signed,
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] sum,
    output logic             wrap,
    output step_e            step
);
    localparam int MSB = ACC_W - 1;

    logic carry;
    logic same_sign;
    logic sign_flip;

    assign {carry, sum} = {1'b0, acc_cur} + {1'b0, addend};
    assign same_sign    = (acc_cur[MSB] == addend[MSB]);
    assign sign_flip    = (sum[MSB] != acc_cur[MSB]);

    always_comb begin
        wrap = 1'b0;
        step = STEP_NONE;
        if (is_signed) begin
            if (same_sign && sign_flip) begin
                wrap = 1'b1;
                step = addend[MSB] ? STEP_DOWN : STEP_UP;
            end
        end else if (carry) begin
            wrap = 1'b1;
            step = STEP_UP;
        end
    end
endmodule

// File: rtl/mac_ovf_unit.sv
module mac_ovf_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 9,
    parameter int ACC_W = 2 * mac_pkg::native_width(OP_W) + 2,
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             acc_en,
    input  logic             is_signed,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] acc_out,
    output logic             wrap_pulse,
    output logic [EXT_W-1:0] ext_hi
);
    localparam int NAT_W = native_width(OP_W);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             wrap;
        logic [EXT_W-1:0] ext;
    } mac_state_t;

    mac_state_t       st_d;
    mac_state_t       st_q;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] sum;
    logic             wrap_now;
    step_e            step;

    mac_mult #(.OP_W(OP_W), .NAT_W(NAT_W), .ACC_W(ACC_W)) u_mult (
        .is_signed(is_signed),
        .op_a     (op_a),
        .op_b     (op_b),
        .addend   (addend)
    );

    mac_wrap_detect #(.ACC_W(ACC_W)) u_wrap (
        .is_signed(is_signed),
        .acc_cur  (st_q.acc),
        .addend   (addend),
        .sum      (sum),
        .wrap     (wrap_now),
        .step     (step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (load) begin
            st_d.acc = acc_en ? addend : '0;
            st_d.ext = '0;
        end else if (acc_en) begin
            st_d.acc  = sum;
            st_d.wrap = wrap_now;
            case (step)
                STEP_UP:   st_d.ext = st_q.ext + 1'b1;
                STEP_DOWN: st_d.ext = st_q.ext - 1'b1;
                default:   st_d.ext = st_q.ext;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out    = st_q.acc;
    assign wrap_pulse = st_q.wrap;
    assign ext_hi     = st_q.ext;
endmodule

// File: rtl/mac_ovf_unit_chk.sv
module mac_ovf_unit_chk #(
    parameter int ACC_W = 20,
    parameter int EXT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             acc_en,
    input logic             is_signed,
    input logic [ACC_W-1:0] acc_out,
    input logic             wrap_pulse,
    input logic [EXT_W-1:0] ext_hi
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_out == '0 && !wrap_pulse && ext_hi == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !acc_en) |=> ($stable(acc_out) && $stable(ext_hi) && !wrap_pulse));

    p_load_clear_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (!wrap_pulse && ext_hi == '0));

    p_load_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !acc_en) |=> (acc_out == '0));

    p_unsigned_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !load && !is_signed) |=> (wrap_pulse == (acc_out < $past(acc_out))));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> ($past(acc_en) && !$past(load)));

    p_ext_unsigned_step_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !load && !is_signed) |=>
            (EXT_W'(ext_hi - $past(ext_hi)) == EXT_W'(wrap_pulse)));

    p_ext_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> (wrap_pulse || $stable(ext_hi)));
endmodule

bind mac_ovf_unit mac_ovf_unit_chk #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .acc_en    (acc_en),
    .is_signed (is_signed),
    .acc_out   (acc_out),
    .wrap_pulse(wrap_pulse),
    .ext_hi    (ext_hi)
);

// File: tb/mac_ovf_unit_bench.sv
module mac_ovf_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W  = 5;
    localparam int ACC_W = 12;
    localparam int EXT_W = 4;

    typedef struct packed {
        logic             ld;
        logic             en;
        logic             sg;
        logic [OP_W-1:0]  a;
        logic [OP_W-1:0]  b;
        logic [ACC_W-1:0] acc;
        logic             ovf;
        logic [EXT_W-1:0] ext;
        logic [3:0]       req;
    } vec_t;

    localparam int NVEC = 21;
    // 5'd16 is -16 and 5'd26 is -6 when is_signed=1
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 1'b0, 5'd31, 5'd31, 12'd961,  1'b0, 4'd0, 4'd5}, // R5
        '{1'b0, 1'b1, 1'b0, 5'd31, 5'd31, 12'd1922, 1'b0, 4'd0, 4'd3}, // R3
        '{1'b0, 1'b1, 1'b0, 5'd31, 5'd31, 12'd2883, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b0, 5'd31, 5'd31, 12'd3844, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b0, 5'd31, 5'd31, 12'd709,  1'b1, 4'd1, 4'd6}, // R6
        '{1'b0, 1'b0, 1'b0, 5'd31, 5'd31, 12'd709,  1'b0, 4'd1, 4'd4}, // R4
        '{1'b0, 1'b1, 1'b0, 5'd0,  5'd5,  12'd709,  1'b0, 4'd1, 4'd8}, // R8
        '{1'b1, 1'b0, 1'b0, 5'd31, 5'd31, 12'd0,    1'b0, 4'd0, 4'd5},
        '{1'b1, 1'b1, 1'b1, 5'd16, 5'd16, 12'd256,  1'b0, 4'd0, 4'd5},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd512,  1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd768,  1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd1024, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd1280, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd1536, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd1792, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 12'd2048, 1'b1, 4'd1, 4'd7}, // R7
        '{1'b0, 1'b1, 1'b1, 5'd26, 5'd1,  12'd2042, 1'b1, 4'd0, 4'd9}, // R9, R10
        '{1'b0, 1'b1, 1'b1, 5'd26, 5'd1,  12'd2036, 1'b0, 4'd0, 4'd8},
        '{1'b1, 1'b1, 1'b0, 5'd26, 5'd1,  12'd26,   1'b0, 4'd0, 4'd2}, // R2
        '{1'b1, 1'b1, 1'b1, 5'd26, 5'd1,  12'd4090, 1'b0, 4'd0, 4'd2},
        '{1'b0, 1'b1, 1'b1, 5'd16, 5'd15, 12'd3850, 1'b0, 4'd0, 4'd3}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             load;
    logic             acc_en;
    logic             is_signed;
    logic [OP_W-1:0]  op_a;
    logic [OP_W-1:0]  op_b;
    logic [ACC_W-1:0] acc_out;
    logic             wrap_pulse;
    logic [EXT_W-1:0] ext_hi;

    int  tests  = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_ovf_unit #(.OP_W(OP_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) u_mac_ovf_unit (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .acc_en    (acc_en),
        .is_signed (is_signed),
        .op_a      (op_a),
        .op_b      (op_b),
        .acc_out   (acc_out),
        .wrap_pulse(wrap_pulse),
        .ext_hi    (ext_hi)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic ld, input logic en, input logic sg,
                        input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        @(negedge clk);
        load = ld; acc_en = en; is_signed = sg; op_a = a; op_b = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load = 1'b0; acc_en = 1'b0; is_signed = 1'b0;
        op_a = '0; op_b = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 acc", int'(acc_out), 0);
        check("R1 wrap", int'(wrap_pulse), 0);
        check("R1 ext", int'(ext_hi), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].ld, VEC[i].en, VEC[i].sg, VEC[i].a, VEC[i].b);
            check($sformatf("R%0d row %0d acc", VEC[i].req, i), int'(acc_out), int'(VEC[i].acc));
            check($sformatf("R%0d row %0d wrap", VEC[i].req, i), int'(wrap_pulse), int'(VEC[i].ovf));
            check($sformatf("R%0d row %0d ext", VEC[i].req, i), int'(ext_hi), int'(VEC[i].ext));
        end

        // R9 and R10: signed down-count through zero; -16*15 = -240 per term
        step(1'b1, 1'b1, 1'b1, 5'd16, 5'd15);
        check("R5 load -240", int'(acc_out), 3856);
        for (int k = 1; k <= 7; k++) begin
            step(1'b0, 1'b1, 1'b1, 5'd16, 5'd15);
            check($sformatf("R7 no wrap at term %0d", k + 1), int'(wrap_pulse), 0);
        end
        step(1'b0, 1'b1, 1'b1, 5'd16, 5'd15);
        // -2160 = -1 * 4096 + 1936
        check("R10 acc after negative wrap", int'(acc_out), 1936);
        check("R7 negative wrap pulse", int'(wrap_pulse), 1);
        check("R9 ext underflow to 15", int'(ext_hi), 15);
        step(1'b0, 1'b0, 1'b1, 5'd16, 5'd15);
        check("R8 pulse drops after one cycle", int'(wrap_pulse), 0);
        check("R4 ext held", int'(ext_hi), 15);

        // R1: reset during a run wins over load
        @(negedge clk);
        rst = 1'b1; load = 1'b1; acc_en = 1'b1; op_a = 5'd3; op_b = 5'd3;
        @(posedge clk);
        #1;
        check("R1 mid-run acc", int'(acc_out), 0);
        check("R1 mid-run ext", int'(ext_hi), 0);
        @(negedge clk);
        rst = 1'b0; load = 1'b0; acc_en = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule